// File: doc/BRIEF.md
# DMA Stream Event Flag Bank

This block keeps the sticky event flags of an eight-stream DMA controller. Each stream reports five kinds of event as single-cycle pulses: transfer complete, half transfer, transfer error, direct-mode error and FIFO error. A pulse sets the matching flag. The flag then stays set until software writes a one to the same bit position of a clear word. Each stream also drives an interrupt line, formed from its flags and its enable inputs.

Software sees the flags through two read-only status words. The low word carries streams 0 to 3 and the high word carries streams 4 to 7. Inside each word, every stream owns a six-bit field, and the fields start at bit 0, 6, 16 and 22 for the four streams of that word. Two write-only clear words use the same layout. The register port is a plain address, write-strobe and data interface, and reads return data combinationally.

The reset input is asynchronous and active low. Assertion takes effect at once, and release is synchronised to the clock over two cycles.

Top module: `dma_evt_flag_bank`

## Requirements
- R1: While reset is asserted, and after it is asserted asynchronously at any time, every flag is zero, both status words read zero and every irq bit is low, whatever the enables are.
- R2: An event pulse on stream s sets that stream's flag at the next rising edge. The field bit positions are: complete = bit 5, half = bit 4, transfer error = bit 3, direct-mode error = bit 2, FIFO error = bit 0.
- R3: Address 0 reads the low status word (streams 0-3) and address 1 reads the high status word (streams 4-7). The field of stream s starts at bit 0, 6, 16 or 22 for s mod 4 = 0, 1, 2 or 3.
- R4: Bit 1 of every field and all bits outside the fields (bits 12-15 and 28-31) read zero, so each field is masked with 0x3D.
- R5: A write to address 2 (low clear word) or address 3 (high clear word) clears, at the next edge, every flag whose bit in the written data is 1. Bits written as 0 leave their flags unchanged.
- R6: When an event pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R7: Reads of addresses 2 and 3 return zero, and writes to addresses 0 and 1 change no flag.
- R8: irq[s] is (complete AND ie_tc[s]) OR (half AND ie_ht[s]) OR ((transfer error OR FIFO error) AND ie_err[s]) OR (direct-mode error AND ie_dme[s]), using that stream's flags. It follows flag and enable changes without added delay.
- R9: A flag stays set while no clear of it occurs, after its event pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word address: 0/1 status low/high, 2/3 clear low/high |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_tc | input | 8 | Transfer-complete pulses, one per stream |
| evt_ht | input | 8 | Half-transfer pulses |
| evt_te | input | 8 | Transfer-error pulses |
| evt_dme | input | 8 | Direct-mode-error pulses |
| evt_fe | input | 8 | FIFO-error pulses |
| ie_tc | input | 8 | Complete interrupt enables |
| ie_ht | input | 8 | Half interrupt enables |
| ie_err | input | 8 | Enables for transfer error and FIFO error |
| ie_dme | input | 8 | Direct-mode-error interrupt enables |
| irq | output | 8 | Per-stream interrupt lines |

## Verification
The per-cycle checks cover the flag updates in every stream cell:

- An event sets its flag.
- A clear without a same-cycle event removes the flag.
- An event wins over a clear in the same cycle.
- Flags only rise while no clear is written.
- An interrupt never rises without a flag.

On the port side, the per-cycle checks also confirm that reserved status bits and clear-word reads stay zero. Only the bench scenarios can show the following:

- The exact field offsets across both words.
- That writes to status addresses and zero bits in a clear write are ignored.
- The enable-to-interrupt mapping.
- The asynchronous clearing of all flags by a mid-run reset.

// File: rtl/evtflag_pkg.sv
package evtflag_pkg;

  localparam int WORD_W  = 32;
  localparam int FIELD_W = 6;
  localparam int LANES   = 4;

  // bit positions inside one stream field (decoded by software)
  localparam int B_TC  = 5;
  localparam int B_HT  = 4;
  localparam int B_TE  = 3;
  localparam int B_DME = 2;
  localparam int B_FE  = 0;

  localparam logic [FIELD_W-1:0] FIELD_MASK = 6'h3D;

  typedef struct packed {
    logic tc;
    logic ht;
    logic te;
    logic dme;
    logic fe;
  } evt_t;

  typedef struct packed {
    logic tc;
    logic ht;
    logic err;
    logic dme;
  } irq_en_t;

  // start bit of lane k inside a word: 0, 6, 16, 22
  function automatic int lane_offset(input int k);
    return ((k / 2) % 2) * 16 + (k % 2) * 6;
  endfunction

  function automatic logic [WORD_W-1:0] word_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      m = m | (WORD_W'(FIELD_MASK) << lane_offset(k));
    end
    return m;
  endfunction

endpackage

// File: rtl/evtflag_cell.sv
module evtflag_cell
  import evtflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  evt_t               evt_i,
  input  logic [FIELD_W-1:0] clr_i,
  input  irq_en_t            en_i,
  output logic [FIELD_W-1:0] field_o,
  output logic               irq_o
);

  logic [FIELD_W-1:0] evt_vec;
  logic [FIELD_W-1:0] flag_q;
  logic [FIELD_W-1:0] flag_d;
  logic               flag_en;

  always_comb begin
    evt_vec        = '0;
    evt_vec[B_TC]  = evt_i.tc;
    evt_vec[B_HT]  = evt_i.ht;
    evt_vec[B_TE]  = evt_i.te;
    evt_vec[B_DME] = evt_i.dme;
    evt_vec[B_FE]  = evt_i.fe;
  end

  // next state: clear first, then events win
  always_comb begin
    flag_d  = ((flag_q & ~clr_i) | evt_vec) & FIELD_MASK;
    flag_en = (|evt_vec) | (|(clr_i & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign field_o = flag_q;

  always_comb begin
    irq_o = (flag_q[B_TC]  & en_i.tc)
          | (flag_q[B_HT]  & en_i.ht)
          | ((flag_q[B_TE] | flag_q[B_FE]) & en_i.err)
          | (flag_q[B_DME] & en_i.dme);
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((field_o & $past(evt_vec)) == $past(evt_vec)));

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_vec & field_o) != '0) |=>
      ((field_o & $past(clr_i & ~evt_vec)) == '0));

  assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & clr_i) != '0) |=>
      ((field_o & $past(evt_vec & clr_i)) == $past(evt_vec & clr_i)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((field_o & $past(field_o)) == $past(field_o)));

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (field_o != '0));

endmodule

// File: rtl/evtflag_word_pack.sv
module evtflag_word_pack
  import evtflag_pkg::*;
(
  input  logic [LANES-1:0][FIELD_W-1:0] fields_i,
  input  logic [WORD_W-1:0]             clr_word_i,
  output logic [WORD_W-1:0]             status_o,
  output logic [LANES-1:0][FIELD_W-1:0] clr_fields_o
);

  logic unused_wbits;
  assign unused_wbits = ^(clr_word_i & ~word_mask());

  always_comb begin
    status_o = '0;
    for (int k = 0; k < LANES; k++) begin
      status_o[lane_offset(k) +: FIELD_W] = fields_i[k] & FIELD_MASK;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int OFF = lane_offset(k);
    assign clr_fields_o[k] = clr_word_i[OFF +: FIELD_W];
  end

endmodule

// File: rtl/evtflag_regport.sv
module evtflag_regport
  import evtflag_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] status_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] clr_o,
  output logic [WORD_W-1:0]              rdata_o
);

  logic is_status;

  // clear words: write-only, one strobe per word
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      clr_o[w] = (wr_i && (addr_i == ADDR_W'(NUM_WORDS + w))) ? wdata_i : '0;
    end
  end

  always_comb begin
    rdata_o   = '0;
    is_status = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == ADDR_W'(w)) begin
        rdata_o   = status_i[w];
        is_status = 1'b1;
      end
    end
  end

  assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr_i) >= NUM_WORDS) |-> (rdata_o == '0));

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_status |-> ((rdata_o & ~word_mask()) == '0));

endmodule

// File: rtl/dma_evt_flag_bank.sv
module dma_evt_flag_bank
  import evtflag_pkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_STREAMS-1:0] evt_tc,
  input  logic [NUM_STREAMS-1:0] evt_ht,
  input  logic [NUM_STREAMS-1:0] evt_te,
  input  logic [NUM_STREAMS-1:0] evt_dme,
  input  logic [NUM_STREAMS-1:0] evt_fe,
  input  logic [NUM_STREAMS-1:0] ie_tc,
  input  logic [NUM_STREAMS-1:0] ie_ht,
  input  logic [NUM_STREAMS-1:0] ie_err,
  input  logic [NUM_STREAMS-1:0] ie_dme,
  output logic [NUM_STREAMS-1:0] irq
);

  localparam int NUM_WORDS = NUM_STREAMS / LANES;
  localparam int ADDR_W    = $clog2(2 * NUM_WORDS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic [NUM_STREAMS-1:0][FIELD_W-1:0] flag_field;
  logic [NUM_STREAMS-1:0][FIELD_W-1:0] clr_field;
  logic [NUM_WORDS-1:0][WORD_W-1:0]    status_word;
  logic [NUM_WORDS-1:0][WORD_W-1:0]    clr_word;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    evt_t    evt_s;
    irq_en_t en_s;

    assign evt_s = '{tc: evt_tc[s], ht: evt_ht[s], te: evt_te[s],
                     dme: evt_dme[s], fe: evt_fe[s]};
    assign en_s  = '{tc: ie_tc[s], ht: ie_ht[s], err: ie_err[s], dme: ie_dme[s]};

    evtflag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .evt_i   (evt_s),
      .clr_i   (clr_field[s]),
      .en_i    (en_s),
      .field_o (flag_field[s]),
      .irq_o   (irq[s])
    );
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    evtflag_word_pack u_pack (
      .fields_i     (flag_field[w*LANES +: LANES]),
      .clr_word_i   (clr_word[w]),
      .status_o     (status_word[w]),
      .clr_fields_o (clr_field[w*LANES +: LANES])
    );
  end

  logic [ADDR_W-1:0] addr_int;
  assign addr_int = ADDR_W'(reg_addr);

  evtflag_regport #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_regport (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .addr_i   (addr_int),
    .wr_i     (reg_wr),
    .wdata_i  (reg_wdata),
    .status_i (status_word),
    .clr_o    (clr_word),
    .rdata_o  (reg_rdata)
  );

endmodule

// File: tb/dma_evt_flag_bank_tb_top.sv
module dma_evt_flag_bank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_tc, evt_ht, evt_te, evt_dme, evt_fe;
  logic [7:0]  ie_tc, ie_ht, ie_err, ie_dme;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;

  dma_evt_flag_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_tc(evt_tc), .evt_ht(evt_ht), .evt_te(evt_te), .evt_dme(evt_dme),
    .evt_fe(evt_fe), .ie_tc(ie_tc), .ie_ht(ie_ht), .ie_err(ie_err),
    .ie_dme(ie_dme), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  tc, ht, te, dme, fe;
    logic [31:0] lo, hi;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 32'h0,        8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0000_0020, 32'h0000_0000}, // R2 R3 s0 tc
    '{1'b0, 2'd0, 32'h0,        8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 32'h0000_0420, 32'h0000_0000}, // R9 s1 ht
    '{1'b0, 2'd0, 32'h0,        8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 32'h0008_0420, 32'h0000_0000}, // s2 te
    '{1'b0, 2'd0, 32'h0,        8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 32'h0108_0420, 32'h0000_0000}, // s3 dme
    '{1'b0, 2'd0, 32'h0,        8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 32'h0108_0420, 32'h0000_0001}, // s4 fe high word
    '{1'b0, 2'd0, 32'h0,        8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 32'h0108_0420, 32'h0F40_0001}, // s7 all
    '{1'b1, 2'd2, 32'h20,       8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0108_0400, 32'h0F40_0001}, // R5 clear s0 tc
    '{1'b1, 2'd0, 32'hFFFFFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0108_0400, 32'h0F40_0001}, // R7 status write
    '{1'b1, 2'd3, 32'hFFFFFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0108_0400, 32'h0000_0000}, // R5 clear high
    '{1'b1, 2'd2, 32'h0,        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0108_0400, 32'h0000_0000}, // R5 zeros
    '{1'b1, 2'd2, 32'h400,      8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 32'h0108_0400, 32'h0000_0000}, // R6 event wins
    '{1'b1, 2'd2, 32'h2,        8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0108_0400, 32'h0000_0800}, // R4 rsvd clear, s5 tc
    '{1'b1, 2'd2, 32'hFFFFFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0000_0000, 32'h0000_0800}, // R5 clear low
    '{1'b0, 2'd0, 32'h0,        8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 32'h0F7D_0F7D, 32'h0F7D_0F7D}  // R4 full mask
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                      input logic [7:0] tc, input logic [7:0] ht, input logic [7:0] te,
                      input logic [7:0] dme, input logic [7:0] fe);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    evt_tc = tc; evt_ht = ht; evt_te = te; evt_dme = dme; evt_fe = fe;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    evt_tc = '0; evt_ht = '0; evt_te = '0; evt_dme = '0; evt_fe = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    evt_tc = '0; evt_ht = '0; evt_te = '0; evt_dme = '0; evt_fe = '0;
    ie_tc = 8'hFF; ie_ht = 8'hFF; ie_err = 8'hFF; ie_dme = 8'hFF;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, d); chk("R1 low status in reset", d, 32'h0);
    rd(2'd1, d); chk("R1 high status in reset", d, 32'h0);
    chk("R1 irq in reset", {24'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    ie_tc = '0; ie_ht = '0; ie_err = '0; ie_dme = '0;

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].tc, VEC[i].ht,
           VEC[i].te, VEC[i].dme, VEC[i].fe);
      rd(2'd0, d); chk($sformatf("vec %0d low word (R2 R3 R4 R5 R6 R7 R9)", i), d, VEC[i].lo);
      rd(2'd1, d); chk($sformatf("vec %0d high word (R2 R3 R4 R5 R6 R7 R9)", i), d, VEC[i].hi);
    end

    // R5: clear both words
    step(1'b1, 2'd2, 32'hFFFFFFFF, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    step(1'b1, 2'd3, 32'hFFFFFFFF, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    rd(2'd0, d); chk("R5 low cleared", d, 32'h0);
    rd(2'd1, d); chk("R5 high cleared", d, 32'h0);

    // R8: complete enable on stream 5
    step(1'b0, 2'd0, 32'h0, 8'h20, 8'h0, 8'h0, 8'h0, 8'h0);
    ie_tc = 8'h20; #1;
    chk("R8 tc enable s5", {24'h0, irq}, 32'h20);
    ie_tc = 8'hDF; #1;
    chk("R8 other enables no irq", {24'h0, irq}, 32'h0);
    ie_tc = 8'h00;

    // R8: FIFO error under error enable
    step(1'b0, 2'd0, 32'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h04);
    ie_err = 8'h04; #1;
    chk("R8 fe via err enable s2", {24'h0, irq}, 32'h04);
    ie_dme = 8'hFF; ie_ht = 8'hFF; #1;
    chk("R8 unrelated enables", {24'h0, irq}, 32'h04);

    // R7: clear words read zero while flags set
    rd(2'd2, d); chk("R7 low clear reads zero", d, 32'h0);
    rd(2'd3, d); chk("R7 high clear reads zero", d, 32'h0);

    // R9: flags persist with no stimulus
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, d); chk("R9 s2 fe sticky", d, 32'h0001_0000);
    rd(2'd1, d); chk("R9 s5 tc sticky", d, 32'h0000_0800);

    // R1: asynchronous reset mid-run
    ie_tc = 8'hFF; ie_err = 8'hFF;
    #2;
    rst_n = 1'b0;
    #1;
    rd(2'd0, d); chk("R1 async reset low", d, 32'h0);
    rd(2'd1, d); chk("R1 async reset high", d, 32'h0);
    chk("R1 async reset irq", {24'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: event works again after reset
    step(1'b0, 2'd0, 32'h0, 8'h01, 8'h0, 8'h0, 8'h0, 8'h0);
    rd(2'd0, d); chk("R2 set after reset", d, 32'h20);
    chk("R8 irq after reset s0", {24'h0, irq}, 32'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule